// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block is the control plane and data path of a four-by-four nonblocking crosspoint. A parallel host port (select, write, read and update strobes, a 3-bit address and a 3-bit bidirectional data bus) programs which input lane each output lane carries, whether each output is enabled, and an equalizer enable flag per input. Single-bit lanes stand in for the switched channels. Any input can drive any output. One input can feed several outputs or all of them.

All configuration is held in two ranks. Host writes land in a staging rank. An update strobe moves the whole staging rank into the active rank in one clock, so a batch of routing changes reaches every output together. The active rank drives the output multiplexers and the equalizer enables, and it is the rank that readback returns.

Two mode pins change this behaviour. In write-through mode, a write goes to both ranks at once. In split mode, the array acts as two independent 2x2 switches that are also written through. Host pins are registered once in the block clock. A strobe acts on the clock edge after the one where it is first seen asserted together with select.

Top module: `xpt_xbar_ctrl`

## Requirements
- R1: Each output lane whose active entry is enabled equals the input lane named by its 2-bit select, combinationally. Any number of outputs may name the same input.
- R2: A write stores into the staging rank only and leaves outputs, equalizer enables and readback unchanged. A write is a rising edge of select-and-write. Address bit 2 = 0 with bits 1:0 naming an output. Data bits 1:0 are the input select and data bit 2 is the output enable.
- R3: A rising edge of select-and-update copies every staging entry, routes and equalizer flags alike, into the active rank in the same clock.
- R4: With the write-through pin high, a write updates both ranks, so the output changes without an update strobe.
- R5: While select and read are high, the bus carries the addressed active entry: {enable, select} for a route, or {2'b00, flag} for an equalizer. The block stops driving the bus once the released strobe has been registered.
- R6: An output lane whose active entry is disabled drives logic 0.
- R7: With the split pin high, writes go to both ranks. Select bit 1 of a route write is replaced by bit 1 of the output index, so outputs 0 and 1 only take inputs 0 and 1, and outputs 2 and 3 only take inputs 2 and 3.
- R8: Address bit 2 = 1 with bits 1:0 naming an input writes that input's equalizer flag from data bit 0. The flag is double ranked like the routes, and the active value drives `eq_en`.
- R9: A read of an entry that has a pending staged write returns the active value until an update.
- R10: Strobes act once per assertion: holding a strobe does not repeat it, and data changes while it is held are ignored. A strobe without select does nothing. Host pins are registered, and the action lands on the next edge.
- R11: After reset, both ranks hold every output disabled with select 0, and every equalizer flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host chip select, active high |
| host_wr | input | 1 | Write strobe, active high |
| host_rd | input | 1 | Read strobe, active high |
| host_upd | input | 1 | Update (rank transfer) strobe, active high |
| host_addr | input | 3 | Bit 2 selects equalizer space; bits 1:0 index |
| host_data | inout | 3 | Bidirectional configuration data |
| mode_xpar | input | 1 | Write-through mode |
| mode_split | input | 1 | Dual 2x2 mode |
| lane_in | input | 4 | Input data lanes |
| lane_out | output | 4 | Routed output lanes |
| eq_en | output | 4 | Active equalizer enable per input |

## Verification
A wrong active-rank entry shows at once on the lane it controls. The bench drives fresh random lane data every cycle, so a bad select or enable shows as a lane mismatch in the first cycle after the faulty edge. It also shows on the bus at the next readback. A wrong staging entry stays hidden until an update. For that reason, every staged batch is followed by an update and by comparisons of the lanes and the bus against a per-clock model. A strobe that fires twice or a bus that is not released shows within one cycle: as a changed entry, or as contention with the value the bench drives.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    parameter int unsigned XPT_PORTS = 4;
    localparam int unsigned XPT_SEL_W = $clog2(XPT_PORTS);
    localparam int unsigned XPT_ADDR_W = XPT_SEL_W + 1;
    localparam int unsigned XPT_DATA_W = XPT_SEL_W + 1;

    typedef struct packed {
        logic                 en;
        logic [XPT_SEL_W-1:0] sel;
    } xpt_route_t;

    typedef xpt_route_t [XPT_PORTS-1:0] xpt_route_vec_t;

    typedef struct packed {
        logic                  sel;
        logic                  wr;
        logic                  rd;
        logic                  upd;
        logic [XPT_ADDR_W-1:0] addr;
        logic [XPT_DATA_W-1:0] data;
        logic                  xpar;
        logic                  split;
    } xpt_host_smp_t;

    typedef struct packed {
        xpt_host_smp_t smp;
        logic          wr_hist;
        logic          upd_hist;
    } xpt_sync_st_t;

    typedef struct packed {
        xpt_route_vec_t       r1;
        xpt_route_vec_t       r2;
        logic [XPT_PORTS-1:0] eq1;
        logic [XPT_PORTS-1:0] eq2;
    } xpt_rank_st_t;
endpackage

// File: rtl/xpt_host_sync.sv
module xpt_host_sync
    import xpt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_sel,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic                  host_upd,
    input  logic [XPT_ADDR_W-1:0] host_addr,
    input  logic [XPT_DATA_W-1:0] host_wdata,
    input  logic                  mode_xpar,
    input  logic                  mode_split,
    output logic                  wr_pulse,
    output logic                  upd_pulse,
    output logic                  rd_active,
    output logic [XPT_ADDR_W-1:0] addr_q,
    output logic [XPT_DATA_W-1:0] data_q,
    output logic                  xpar_q,
    output logic                  split_q
);
    xpt_sync_st_t st_d, st_q;
    logic wr_lvl, upd_lvl;

    always_comb begin
        wr_lvl            = st_q.smp.sel & st_q.smp.wr;
        upd_lvl           = st_q.smp.sel & st_q.smp.upd;
        st_d              = st_q;
        st_d.smp.sel      = host_sel;
        st_d.smp.wr       = host_wr;
        st_d.smp.rd       = host_rd;
        st_d.smp.upd      = host_upd;
        st_d.smp.addr     = host_addr;
        st_d.smp.data     = host_wdata;
        st_d.smp.xpar     = mode_xpar;
        st_d.smp.split    = mode_split;
        st_d.wr_hist      = wr_lvl;
        st_d.upd_hist     = upd_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_pulse  = wr_lvl & ~st_q.wr_hist;
    assign upd_pulse = upd_lvl & ~st_q.upd_hist;
    assign rd_active = st_q.smp.sel & st_q.smp.rd;
    assign addr_q    = st_q.smp.addr;
    assign data_q    = st_q.smp.data;
    assign xpar_q    = st_q.smp.xpar;
    assign split_q   = st_q.smp.split;
endmodule

// File: rtl/xpt_cfg_ranks.sv
module xpt_cfg_ranks
    import xpt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_pulse,
    input  logic                  upd_pulse,
    input  logic [XPT_ADDR_W-1:0] addr_q,
    input  logic [XPT_DATA_W-1:0] data_q,
    input  logic                  xpar_q,
    input  logic                  split_q,
    output xpt_route_vec_t        rank1,
    output xpt_route_vec_t        rank2,
    output logic [XPT_PORTS-1:0]  eq_act,
    output logic [XPT_DATA_W-1:0] rd_word
);
    xpt_rank_st_t         st_d, st_q;
    xpt_route_t           entry;
    logic [XPT_SEL_W-1:0] idx;
    logic                 is_eq;
    logic                 direct;

    always_comb begin
        idx       = addr_q[XPT_SEL_W-1:0];
        is_eq     = addr_q[XPT_SEL_W];
        direct    = xpar_q | split_q;
        entry.en  = data_q[XPT_SEL_W];
        entry.sel = data_q[XPT_SEL_W-1:0];
        if (split_q) entry.sel[XPT_SEL_W-1] = idx[XPT_SEL_W-1];

        st_d = st_q;
        if (upd_pulse) begin
            st_d.r2  = st_q.r1;
            st_d.eq2 = st_q.eq1;
        end
        if (wr_pulse) begin
            if (is_eq) begin
                st_d.eq1[idx] = data_q[0];
                if (direct) st_d.eq2[idx] = data_q[0];
            end else begin
                st_d.r1[idx] = entry;
                if (direct) st_d.r2[idx] = entry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (is_eq) rd_word = {{(XPT_DATA_W-1){1'b0}}, st_q.eq2[idx]};
        else       rd_word = st_q.r2[idx];
    end

    assign rank1  = st_q.r1;
    assign rank2  = st_q.r2;
    assign eq_act = st_q.eq2;
endmodule

// File: rtl/xpt_route_mux.sv
module xpt_route_mux
    import xpt_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b0
) (
    input  xpt_route_vec_t       rank2,
    input  logic [XPT_PORTS-1:0] lane_in,
    output logic [XPT_PORTS-1:0] lane_out
);
    for (genvar o = 0; o < XPT_PORTS; o++) begin : g_out
        assign lane_out[o] = rank2[o].en ? lane_in[rank2[o].sel] : IDLE_LVL;
    end
endmodule

// File: rtl/xpt_xbar_ctrl.sv
module xpt_xbar_ctrl
    import xpt_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_sel,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic                  host_upd,
    input  logic [XPT_ADDR_W-1:0] host_addr,
    inout  wire  [XPT_DATA_W-1:0] host_data,
    input  logic                  mode_xpar,
    input  logic                  mode_split,
    input  logic [XPT_PORTS-1:0]  lane_in,
    output logic [XPT_PORTS-1:0]  lane_out,
    output logic [XPT_PORTS-1:0]  eq_en
);
    logic                  wr_pulse_w, upd_pulse_w, rd_active_w;
    logic                  xpar_q_w, split_q_w;
    logic [XPT_ADDR_W-1:0] addr_q_w;
    logic [XPT_DATA_W-1:0] data_q_w, rd_word_w;
    xpt_route_vec_t        rank1_w, rank2_w;

    xpt_host_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_upd   (host_upd),
        .host_addr  (host_addr),
        .host_wdata (host_data),
        .mode_xpar  (mode_xpar),
        .mode_split (mode_split),
        .wr_pulse   (wr_pulse_w),
        .upd_pulse  (upd_pulse_w),
        .rd_active  (rd_active_w),
        .addr_q     (addr_q_w),
        .data_q     (data_q_w),
        .xpar_q     (xpar_q_w),
        .split_q    (split_q_w)
    );

    xpt_cfg_ranks u_ranks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pulse  (wr_pulse_w),
        .upd_pulse (upd_pulse_w),
        .addr_q    (addr_q_w),
        .data_q    (data_q_w),
        .xpar_q    (xpar_q_w),
        .split_q   (split_q_w),
        .rank1     (rank1_w),
        .rank2     (rank2_w),
        .eq_act    (eq_en),
        .rd_word   (rd_word_w)
    );

    xpt_route_mux #(.IDLE_LVL(IDLE_LVL)) u_mux (
        .rank2    (rank2_w),
        .lane_in  (lane_in),
        .lane_out (lane_out)
    );

    assign host_data = rd_active_w ? rd_word_w : {XPT_DATA_W{1'bz}};
endmodule

// File: rtl/xpt_cfg_chk.sv
module xpt_cfg_chk
    import xpt_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [XPT_PORTS-1:0]  lane_in,
    input logic [XPT_PORTS-1:0]  lane_out,
    input xpt_route_vec_t        rank1,
    input xpt_route_vec_t        rank2,
    input logic                  wr_pulse,
    input logic                  upd_pulse,
    input logic                  xpar_q,
    input logic                  split_q,
    input logic [XPT_ADDR_W-1:0] addr_q
);
    logic direct_wr;
    assign direct_wr = wr_pulse & (xpar_q | split_q);

    AST_RANK2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pulse && !direct_wr) |=> $stable(rank2)); // R2

    AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !direct_wr) |=> (rank2 == $past(rank1))); // R3

    for (genvar o = 0; o < XPT_PORTS; o++) begin : g_chk
        localparam logic HALF = 1'((o >> (XPT_SEL_W - 1)) & 1);

        AST_ROUTE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            rank2[o].en |-> (lane_out[o] == lane_in[rank2[o].sel])); // R1

        AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            !rank2[o].en |-> (lane_out[o] == IDLE_LVL)); // R6

        AST_SPLIT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_pulse && split_q && !addr_q[XPT_SEL_W] && addr_q[XPT_SEL_W-1:0] == XPT_SEL_W'(o))
            |=> (rank2[o].sel[XPT_SEL_W-1] == HALF)); // R7
    end
endmodule

bind xpt_xbar_ctrl xpt_cfg_chk #(.IDLE_LVL(IDLE_LVL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_in   (lane_in),
    .lane_out  (lane_out),
    .rank1     (rank1_w),
    .rank2     (rank2_w),
    .wr_pulse  (wr_pulse_w),
    .upd_pulse (upd_pulse_w),
    .xpar_q    (xpar_q_w),
    .split_q   (split_q_w),
    .addr_q    (addr_q_w)
);

// File: tb/xpt_xbar_ctrl_tb.sv
`timescale 1ns/1ps
module xpt_xbar_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel, wr, rd, upd, xpar, split, drv_en;
    logic [2:0] addr, drv;
    logic [3:0] lane_in;
    wire  [3:0] lane_out, eq_en;
    wire  [2:0] host_data;
    int         vectors = 0, errors = 0;
    bit         done = 1'b0;
    string      cur_req = "R11";

    always #2 clk = ~clk;

    assign host_data = drv_en ? drv : 3'bzzz;

    xpt_xbar_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_wr(wr), .host_rd(rd),
        .host_upd(upd), .host_addr(addr), .host_data(host_data),
        .mode_xpar(xpar), .mode_split(split), .lane_in(lane_in),
        .lane_out(lane_out), .eq_en(eq_en)
    );

    // behavioural reference: registered pin samples, staging and active ranks
    bit       s_sel, s_wr, s_rd, s_upd, s_xpar, s_split, wrh, updh;
    bit [2:0] s_addr, s_data;
    bit [2:0] r1 [4];
    bit [2:0] r2 [4];
    bit [3:0] eq1, eq2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {s_sel, s_wr, s_rd, s_upd, s_xpar, s_split, wrh, updh} = '0;
            s_addr = 0; s_data = 0; eq1 = 0; eq2 = 0;
            for (int k = 0; k < 4; k++) begin r1[k] = 0; r2[k] = 0; end
        end else begin
            bit wp, up, dir;
            bit [1:0] ix;
            bit [2:0] w;
            wp  = s_sel && s_wr && !wrh;
            up  = s_sel && s_upd && !updh;
            dir = s_xpar || s_split;
            ix  = s_addr[1:0];
            if (up) begin
                for (int k = 0; k < 4; k++) r2[k] = r1[k];
                eq2 = eq1;
            end
            if (wp) begin
                if (s_addr[2]) begin
                    eq1[ix] = s_data[0];
                    if (dir) eq2[ix] = s_data[0];
                end else begin
                    w = s_data;
                    if (s_split) w[1] = ix[1];
                    r1[ix] = w;
                    if (dir) r2[ix] = w;
                end
            end
            wrh = s_sel && s_wr; updh = s_sel && s_upd;
            s_sel = sel; s_wr = wr; s_rd = rd; s_upd = upd;
            s_addr = addr; s_data = host_data; s_xpar = xpar; s_split = split;
        end
    end

    task automatic fail(input string what, input int got, input int exp);
        errors++;
        $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    endtask

    task automatic compare();
        bit [3:0] el;
        bit [2:0] ew;
        vectors++;
        for (int o = 0; o < 4; o++) el[o] = r2[o][2] ? lane_in[r2[o][1:0]] : 1'b0;
        if (lane_out !== el) fail("lane_out", lane_out, el);
        if (eq_en !== eq2) fail("eq_en", eq_en, eq2);
        if (s_sel && s_rd) begin
            ew = s_addr[2] ? {2'b00, eq2[s_addr[1:0]]} : r2[s_addr[1:0]];
            if (host_data !== ew) fail("readback", host_data, ew);
        end else if (drv_en) begin
            if (host_data !== drv) fail("bus release", host_data, drv);
        end
    endtask

    initial forever begin
        @(negedge clk); #1;
        if (rst_n && !done) compare();
    end

    initial begin
        lane_in = 0;
        forever begin @(negedge clk); lane_in = 4'($urandom); end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input bit [2:0] a, input bit [2:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; drv_en = 1; drv = d;
        @(negedge clk); sel = 0; wr = 0; drv_en = 0;
        idle(2);
    endtask

    task automatic host_update();
        @(negedge clk); sel = 1; upd = 1;
        @(negedge clk); sel = 0; upd = 0;
        idle(2);
    endtask

    task automatic host_read(input bit [2:0] a);
        @(negedge clk); sel = 1; rd = 1; addr = a; drv_en = 0;
        idle(2);
        @(negedge clk); sel = 0; rd = 0;
        @(negedge clk); drv_en = 1; drv = 3'b111; // R5 released bus carries host value
        @(negedge clk); drv = 3'b000;
        @(negedge clk); drv_en = 0;
    endtask

    initial begin
        {sel, wr, rd, upd, xpar, split, drv_en} = '0;
        addr = 0; drv = 0; rst_n = 0;
        idle(4); rst_n = 1;
        cur_req = "R11"; idle(2);
        for (int a = 0; a < 8; a++) host_read(3'(a));

        cur_req = "R2";  host_write(0, 3'b110); host_write(3, 3'b101); idle(3);
        cur_req = "R9";  host_read(0); host_read(3);
        cur_req = "R3";  host_update(); host_read(0); idle(4);
        cur_req = "R1";
        for (int o = 0; o < 4; o++) host_write(3'(o), 3'b111);
        host_update(); idle(6);
        host_write(0, 3'b101); host_write(1, 3'b101); host_write(2, 3'b100); host_write(3, 3'b110);
        host_update(); idle(6);
        cur_req = "R6";  host_write(2, 3'b011); host_update(); idle(6); host_read(2);
        cur_req = "R4";  xpar = 1; idle(2); host_write(1, 3'b100); idle(4); host_read(1);
        host_write(6, 3'b001); idle(3); xpar = 0; idle(2);
        cur_req = "R7";  split = 1; idle(2);
        host_write(0, 3'b111); host_write(3, 3'b100); host_write(2, 3'b101); host_write(1, 3'b110);
        idle(4); for (int a = 0; a < 4; a++) host_read(3'(a));
        split = 0; idle(2);
        cur_req = "R8";  host_write(4, 3'b001); host_write(5, 3'b111); idle(2); host_read(4);
        host_update(); host_read(4); host_read(5); host_write(4, 3'b000); host_update(); host_read(4);
        cur_req = "R10";
        @(negedge clk); sel = 1; wr = 1; addr = 1; drv_en = 1; drv = 3'b110;
        @(negedge clk); drv = 3'b101;
        @(negedge clk); addr = 2; drv = 3'b111;
        @(negedge clk); sel = 0; wr = 0; drv_en = 0; idle(2);
        @(negedge clk); wr = 1; addr = 3; drv_en = 1; drv = 3'b101;
        @(negedge clk); wr = 0; upd = 1; drv_en = 0;
        @(negedge clk); upd = 0; idle(3);
        host_update(); idle(4);
        for (int a = 0; a < 4; a++) host_read(3'(a));
        @(negedge clk); sel = 1; upd = 1; idle(4);
        @(negedge clk); sel = 0; upd = 0; idle(3);
        cur_req = "R5";  host_read(0); host_read(7);
        idle(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL %s watchdog: got %0h expected %0h", cur_req, 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule